// File: doc/BRIEF.md
# Snooping Write-Through L1 Data Cache with Miss Classification

This block is the private first-level data cache of one core in a two-core cluster whose cores share a second-level cache. It is direct-mapped and write-through. Reads that miss stall the core port and pull a whole block from the shared level through a valid/ready fill handshake. Every local write is forwarded at once to the shared level and is also announced to the peer cache as an invalidation of its block. Invalidations announced by the peer arrive on a snoop input and knock out a matching resident copy.

Each accepted access is sorted into one of six kinds: read hit, write hit, compulsory miss, conflict miss, coherence read miss or coherence write miss. Each kind has its own saturating counter. To do this, every line keeps, besides its tag and valid bit, a flag recording that it has ever been filled and a flag recording that its copy was taken away by a snoop. The tag is kept after invalidation, so it names the last block the line held. The counters are for studying how two cores that share data disturb each other's caches.

Top module: `snoop_l1_cache`

## Requirements
- R1: A read whose block is resident and valid is accepted with `core_req_ready` high and returns the addressed 32-bit word on `core_rsp_rdata` with `core_rsp_valid` one cycle after acceptance. It adds one to `cnt_read_hit`.
- R2: A read miss raises `fill_valid` with the block number on `fill_addr` in the cycle after acceptance. It holds both, with `core_req_ready` low, until `fill_ready` is sampled high. The block on `fill_data` is installed, word w sitting at bits [32w+31:32w], and the addressed word is returned with `core_rsp_valid` one cycle after that handshake.
- R3: Every accepted write, hit or miss, pulses `wt_valid` with the byte address and data, and `snp_out_valid` with the block number (address bits [31:5] by default), one cycle after acceptance. A write hit also updates the stored word and counts in `cnt_write_hit`.
- R4: A write miss installs nothing, so a later read of that block still issues a fill.
- R5: A snoop invalidation whose block number matches a valid resident line clears that line. The next read of the block is a miss counted in `cnt_coh_read`, and the next write of it is a miss counted in `cnt_coh_write`.
- R6: A miss on a line slot that has never been filled is counted in `cnt_compulsory`.
- R7: A miss on a filled slot whose last block differs from the requested one is counted in `cnt_conflict`.
- R8: When a snoop invalidation and a local access hit the same line in the same cycle, the snoop takes effect first, and the access is classified as a coherence miss.
- R9: A snoop whose block is not resident (different tag, or another slot) changes no line. Reads of the resident blocks still hit.
- R10: All counters read zero after reset, stop at their all-ones value, and read zero on the cycle after `cnt_clear` is sampled high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| core_req_valid | input | 1 | Core request present |
| core_req_write | input | 1 | 1 = write, 0 = read |
| core_req_addr | input | ADDR_W | Byte address of the access |
| core_req_wdata | input | DATA_W | Write data |
| core_req_ready | output | 1 | Cache can accept a request this cycle |
| core_rsp_valid | output | 1 | Read data valid |
| core_rsp_rdata | output | DATA_W | Read data |
| wt_valid | output | 1 | Write-through to the shared level |
| wt_addr | output | ADDR_W | Write-through byte address |
| wt_data | output | DATA_W | Write-through data |
| snp_out_valid | output | 1 | Invalidation broadcast to the peer |
| snp_out_addr | output | ADDR_W-log2(BLOCK_BYTES) | Block number being invalidated |
| snp_in_valid | input | 1 | Invalidation from the peer |
| snp_in_addr | input | ADDR_W-log2(BLOCK_BYTES) | Block number to invalidate |
| fill_valid | output | 1 | Block fill requested |
| fill_addr | output | ADDR_W-log2(BLOCK_BYTES) | Block number to fill |
| fill_ready | input | 1 | Fill data present, handshake completes |
| fill_data | input | BLOCK_BYTES*8 | Whole block from the shared level |
| cnt_clear | input | 1 | Synchronous counter clear |
| cnt_read_hit | output | CNT_W | Read hits |
| cnt_write_hit | output | CNT_W | Write hits |
| cnt_compulsory | output | CNT_W | Compulsory misses |
| cnt_conflict | output | CNT_W | Conflict misses |
| cnt_coh_read | output | CNT_W | Coherence read misses |
| cnt_coh_write | output | CNT_W | Coherence write misses |

## Verification
A wrong valid bit shows up on the very next access to that block. A read either raises `fill_valid` when it should answer, or answers with a stale word when it should fill. Both are visible one cycle after acceptance. A wrong ever-filled flag, lost-by-snoop flag or kept tag does not change data or timing. It only moves one count between the miss counters, so every scenario reads all six counters after its accesses. The same-cycle snoop case and the case of a snoop that misses are driven on purpose, because an error in the order of the snoop and the lookup shows only as a hit or a miss in that single cycle.

// File: rtl/snl1_pkg.sv
package snl1_pkg;

  typedef enum logic [2:0] {
    ACC_NONE,
    ACC_RD_HIT,
    ACC_WR_HIT,
    ACC_COMPULSORY,
    ACC_CONFLICT,
    ACC_COH_RD,
    ACC_COH_WR
  } acc_kind_e;

  typedef enum logic {
    ST_LOOKUP,
    ST_FILL
  } cache_st_e;

  localparam int unsigned NUM_KINDS = 6;

endpackage

// File: rtl/snl1_classify.sv
module snl1_classify
  import snl1_pkg::*;
(
  input  logic      access,
  input  logic      is_write,
  input  logic      line_valid,
  input  logic      line_ever,
  input  logic      line_lost,
  input  logic      tag_eq,
  output logic      hit,
  output acc_kind_e kind
);

  assign hit = line_valid && tag_eq;

  always_comb begin
    kind = ACC_NONE;
    if (access) begin
      if (hit)                                  kind = is_write ? ACC_WR_HIT : ACC_RD_HIT;
      else if (!line_ever)                      kind = ACC_COMPULSORY;
      else if (!line_valid && line_lost && tag_eq) kind = is_write ? ACC_COH_WR : ACC_COH_RD;
      else                                      kind = ACC_CONFLICT;
    end
  end

endmodule

// File: rtl/snl1_line_store.sv
module snl1_line_store #(
  parameter int unsigned LINES   = 2,
  parameter int unsigned IDX_W   = 1,
  parameter int unsigned TAG_W   = 26,
  parameter int unsigned DATA_W  = 32,
  parameter int unsigned WSEL_W  = 3,
  parameter int unsigned BLOCK_W = 256
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               snp_valid,
  input  logic [IDX_W-1:0]   snp_idx,
  input  logic [TAG_W-1:0]   snp_tag,
  input  logic [IDX_W-1:0]   lk_idx,
  input  logic [TAG_W-1:0]   lk_tag,
  input  logic [WSEL_W-1:0]  lk_wsel,
  output logic               lk_valid,
  output logic               lk_ever,
  output logic               lk_lost,
  output logic               lk_tag_eq,
  output logic [DATA_W-1:0]  lk_word,
  input  logic               fill_en,
  input  logic [IDX_W-1:0]   fill_idx,
  input  logic [TAG_W-1:0]   fill_tag,
  input  logic [BLOCK_W-1:0] fill_block,
  input  logic               wr_en,
  input  logic [IDX_W-1:0]   wr_idx,
  input  logic [WSEL_W-1:0]  wr_wsel,
  input  logic [DATA_W-1:0]  wr_data
);

  logic [LINES-1:0]   valid_q, valid_d, ever_q, ever_d, lost_q, lost_d;
  logic [LINES-1:0]   snp_kill;
  logic [TAG_W-1:0]   tag_q  [LINES];
  logic [BLOCK_W-1:0] data_q [LINES];

  // a snoop only removes a valid copy of exactly the named block
  for (genvar i = 0; i < LINES; i++) begin : g_kill
    assign snp_kill[i] = snp_valid && (snp_idx == IDX_W'(i)) && valid_q[i] && (tag_q[i] == snp_tag);
  end

  // lookup sees the state with this cycle's snoop already applied
  assign lk_valid  = valid_q[lk_idx] & ~snp_kill[lk_idx];
  assign lk_lost   = lost_q[lk_idx] | snp_kill[lk_idx];
  assign lk_ever   = ever_q[lk_idx];
  assign lk_tag_eq = (tag_q[lk_idx] == lk_tag);
  assign lk_word   = data_q[lk_idx][lk_wsel*DATA_W +: DATA_W];

  always_comb begin
    valid_d = valid_q & ~snp_kill;
    lost_d  = lost_q | snp_kill;
    ever_d  = ever_q;
    if (fill_en) begin
      valid_d[fill_idx] = 1'b1;
      ever_d[fill_idx]  = 1'b1;
      lost_d[fill_idx]  = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= '0;
      ever_q  <= '0;
      lost_q  <= '0;
    end else begin
      valid_q <= valid_d;
      ever_q  <= ever_d;
      lost_q  <= lost_d;
    end
  end

  always_ff @(posedge clk) begin
    if (fill_en) begin
      tag_q[fill_idx]  <= fill_tag;
      data_q[fill_idx] <= fill_block;
    end else if (wr_en) begin
      data_q[wr_idx][wr_wsel*DATA_W +: DATA_W] <= wr_data;
    end
  end

endmodule

// File: rtl/snl1_sat_counter.sv
module snl1_sat_counter #(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         inc,
  output logic [W-1:0] count
);

  logic [W-1:0] count_d;

  always_comb begin
    count_d = count;
    if (clr)                     count_d = '0;
    else if (inc && ~&count)     count_d = count + W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) count <= '0;
    else        count <= count_d;
  end

endmodule

// File: rtl/snoop_l1_cache.sv
module snoop_l1_cache
  import snl1_pkg::*;
#(
  parameter int unsigned ADDR_W      = 32,
  parameter int unsigned DATA_W      = 32,
  parameter int unsigned CACHE_BYTES = 64,
  parameter int unsigned BLOCK_BYTES = 32,
  parameter int unsigned CNT_W       = 32
) (
  input  logic                                  clk,
  input  logic                                  rst_n,
  input  logic                                  core_req_valid,
  input  logic                                  core_req_write,
  input  logic [ADDR_W-1:0]                     core_req_addr,
  input  logic [DATA_W-1:0]                     core_req_wdata,
  output logic                                  core_req_ready,
  output logic                                  core_rsp_valid,
  output logic [DATA_W-1:0]                     core_rsp_rdata,
  output logic                                  wt_valid,
  output logic [ADDR_W-1:0]                     wt_addr,
  output logic [DATA_W-1:0]                     wt_data,
  output logic                                  snp_out_valid,
  output logic [ADDR_W-$clog2(BLOCK_BYTES)-1:0] snp_out_addr,
  input  logic                                  snp_in_valid,
  input  logic [ADDR_W-$clog2(BLOCK_BYTES)-1:0] snp_in_addr,
  output logic                                  fill_valid,
  output logic [ADDR_W-$clog2(BLOCK_BYTES)-1:0] fill_addr,
  input  logic                                  fill_ready,
  input  logic [BLOCK_BYTES*8-1:0]              fill_data,
  input  logic                                  cnt_clear,
  output logic [CNT_W-1:0]                      cnt_read_hit,
  output logic [CNT_W-1:0]                      cnt_write_hit,
  output logic [CNT_W-1:0]                      cnt_compulsory,
  output logic [CNT_W-1:0]                      cnt_conflict,
  output logic [CNT_W-1:0]                      cnt_coh_read,
  output logic [CNT_W-1:0]                      cnt_coh_write
);

  localparam int unsigned LINES    = CACHE_BYTES / BLOCK_BYTES;
  localparam int unsigned WORDS    = BLOCK_BYTES / (DATA_W / 8);
  localparam int unsigned BLOCK_W  = BLOCK_BYTES * 8;
  localparam int unsigned OFF_W    = $clog2(BLOCK_BYTES);
  localparam int unsigned BYTE_W   = $clog2(DATA_W / 8);
  localparam int unsigned WSEL_W   = (WORDS > 1) ? $clog2(WORDS) : 1;
  localparam int unsigned IDX_BITS = $clog2(LINES);
  localparam int unsigned IDX_W    = (LINES > 1) ? IDX_BITS : 1;
  localparam int unsigned BLK_W    = ADDR_W - OFF_W;
  localparam int unsigned TAG_W    = BLK_W - IDX_BITS;

  cache_st_e   state_q, state_d;
  acc_kind_e   kind;
  logic        accept, hit;
  logic        lk_valid, lk_ever, lk_lost, lk_tag_eq;
  logic [DATA_W-1:0] lk_word, fill_word;

  logic [BLK_W-1:0]  req_blk, req_blk_q;
  logic [WSEL_W-1:0] req_wsel, req_wsel_q;
  logic [IDX_W-1:0]  req_idx, snp_idx, fill_idx;

  logic              rsp_valid_d, wt_valid_d, fill_en;
  logic [DATA_W-1:0] rsp_data_d;
  logic [NUM_KINDS-1:0] inc_vec;
  logic [CNT_W-1:0]  cnt_q [NUM_KINDS];

  // ---------------- address decode ----------------
  assign req_blk  = core_req_addr[ADDR_W-1:OFF_W];
  assign req_wsel = core_req_addr[BYTE_W +: WSEL_W];

  if (LINES > 1) begin : g_multi
    assign req_idx  = req_blk[IDX_W-1:0];
    assign snp_idx  = snp_in_addr[IDX_W-1:0];
    assign fill_idx = req_blk_q[IDX_W-1:0];
  end else begin : g_single
    assign req_idx  = '0;
    assign snp_idx  = '0;
    assign fill_idx = '0;
  end

  // ---------------- line state and classification ----------------
  snl1_line_store #(
    .LINES(LINES), .IDX_W(IDX_W), .TAG_W(TAG_W),
    .DATA_W(DATA_W), .WSEL_W(WSEL_W), .BLOCK_W(BLOCK_W)
  ) u_store (
    .clk       (clk),
    .rst_n     (rst_n),
    .snp_valid (snp_in_valid),
    .snp_idx   (snp_idx),
    .snp_tag   (snp_in_addr[BLK_W-1 -: TAG_W]),
    .lk_idx    (req_idx),
    .lk_tag    (req_blk[BLK_W-1 -: TAG_W]),
    .lk_wsel   (req_wsel),
    .lk_valid  (lk_valid),
    .lk_ever   (lk_ever),
    .lk_lost   (lk_lost),
    .lk_tag_eq (lk_tag_eq),
    .lk_word   (lk_word),
    .fill_en   (fill_en),
    .fill_idx  (fill_idx),
    .fill_tag  (req_blk_q[BLK_W-1 -: TAG_W]),
    .fill_block(fill_data),
    .wr_en     (accept && core_req_write && hit),
    .wr_idx    (req_idx),
    .wr_wsel   (req_wsel),
    .wr_data   (core_req_wdata)
  );

  snl1_classify u_classify (
    .access    (accept),
    .is_write  (core_req_write),
    .line_valid(lk_valid),
    .line_ever (lk_ever),
    .line_lost (lk_lost),
    .tag_eq    (lk_tag_eq),
    .hit       (hit),
    .kind      (kind)
  );

  // ---------------- control, next state ----------------
  assign core_req_ready = (state_q == ST_LOOKUP);
  assign accept         = core_req_valid && core_req_ready;
  assign fill_valid     = (state_q == ST_FILL);
  assign fill_addr      = req_blk_q;
  assign fill_en        = fill_valid && fill_ready;
  assign fill_word      = fill_data[req_wsel_q*DATA_W +: DATA_W];

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_LOOKUP: if (accept && !core_req_write && !hit) state_d = ST_FILL;
      ST_FILL:   if (fill_ready)                       state_d = ST_LOOKUP;
      default:                                         state_d = ST_LOOKUP;
    endcase
    rsp_valid_d = (accept && !core_req_write && hit) || fill_en;
    rsp_data_d  = fill_en ? fill_word : lk_word;
    wt_valid_d  = accept && core_req_write;
  end

  // ---------------- registers ----------------
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q        <= ST_LOOKUP;
      core_rsp_valid <= 1'b0;
      wt_valid       <= 1'b0;
      snp_out_valid  <= 1'b0;
    end else begin
      state_q        <= state_d;
      core_rsp_valid <= rsp_valid_d;
      wt_valid       <= wt_valid_d;
      snp_out_valid  <= wt_valid_d;
    end
  end

  always_ff @(posedge clk) begin
    if (accept) begin
      req_blk_q  <= req_blk;
      req_wsel_q <= req_wsel;
    end
    if (rsp_valid_d) core_rsp_rdata <= rsp_data_d;
    if (wt_valid_d) begin
      wt_addr      <= core_req_addr;
      wt_data      <= core_req_wdata;
      snp_out_addr <= req_blk;
    end
  end

  // ---------------- event counters ----------------
  assign inc_vec = {kind == ACC_COH_WR, kind == ACC_COH_RD, kind == ACC_CONFLICT,
                    kind == ACC_COMPULSORY, kind == ACC_WR_HIT, kind == ACC_RD_HIT};

  for (genvar k = 0; k < NUM_KINDS; k++) begin : g_cnt
    snl1_sat_counter #(.W(CNT_W)) u_cnt (
      .clk  (clk),
      .rst_n(rst_n),
      .clr  (cnt_clear),
      .inc  (inc_vec[k]),
      .count(cnt_q[k])
    );
  end

  assign cnt_read_hit   = cnt_q[0];
  assign cnt_write_hit  = cnt_q[1];
  assign cnt_compulsory = cnt_q[2];
  assign cnt_conflict   = cnt_q[3];
  assign cnt_coh_read   = cnt_q[4];
  assign cnt_coh_write  = cnt_q[5];

endmodule

// File: rtl/snl1_checker.sv
module snl1_checker #(
  parameter int unsigned BLK_W = 27,
  parameter int unsigned CNT_W = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             core_req_valid,
  input logic             core_req_write,
  input logic             core_req_ready,
  input logic             core_rsp_valid,
  input logic             wt_valid,
  input logic             snp_out_valid,
  input logic             fill_valid,
  input logic [BLK_W-1:0] fill_addr,
  input logic             fill_ready,
  input logic             cnt_clear,
  input logic [CNT_W-1:0] cnt_read_hit,
  input logic [CNT_W-1:0] cnt_conflict,
  input logic [CNT_W-1:0] cnt_coh_read
);

  AST_STALL_IN_FILL: assert property (@(posedge clk) disable iff (!rst_n)
    fill_valid |-> !core_req_ready);  // R2

  AST_FILL_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    fill_valid && !fill_ready |=> fill_valid && $stable(fill_addr));  // R2

  AST_FILL_ANSWERS: assert property (@(posedge clk) disable iff (!rst_n)
    fill_valid && fill_ready |=> core_rsp_valid && !fill_valid);  // R2

  AST_WRITE_BROADCAST: assert property (@(posedge clk) disable iff (!rst_n)
    core_req_valid && core_req_ready && core_req_write |=> wt_valid && snp_out_valid);  // R3

  AST_READ_NO_WT: assert property (@(posedge clk) disable iff (!rst_n)
    core_req_valid && core_req_ready && !core_req_write |=> !wt_valid && !snp_out_valid);  // R3

  AST_CLEAR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_clear |=> cnt_read_hit == '0 && cnt_conflict == '0 && cnt_coh_read == '0);  // R10

  AST_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    !cnt_clear |=> cnt_read_hit >= $past(cnt_read_hit));  // R10

endmodule

bind snoop_l1_cache snl1_checker #(
  .BLK_W(ADDR_W - $clog2(BLOCK_BYTES)),
  .CNT_W(CNT_W)
) u_snl1_checker (
  .clk           (clk),
  .rst_n         (rst_n),
  .core_req_valid(core_req_valid),
  .core_req_write(core_req_write),
  .core_req_ready(core_req_ready),
  .core_rsp_valid(core_rsp_valid),
  .wt_valid      (wt_valid),
  .snp_out_valid (snp_out_valid),
  .fill_valid    (fill_valid),
  .fill_addr     (fill_addr),
  .fill_ready    (fill_ready),
  .cnt_clear     (cnt_clear),
  .cnt_read_hit  (cnt_read_hit),
  .cnt_conflict  (cnt_conflict),
  .cnt_coh_read  (cnt_coh_read)
);

// File: tb/snoop_l1_cache_bench.sv
module snoop_l1_cache_bench;

  localparam int CLK_PERIOD = 10;
  localparam int CNT_W      = 4;
  localparam int BLK_W      = 27;

  logic clk, rst_n;
  logic core_req_valid, core_req_write, core_req_ready, core_rsp_valid;
  logic [31:0] core_req_addr, core_req_wdata, core_rsp_rdata;
  logic wt_valid, snp_out_valid, snp_in_valid, fill_valid, fill_ready, cnt_clear;
  logic [31:0] wt_addr, wt_data;
  logic [BLK_W-1:0] snp_out_addr, snp_in_addr, fill_addr;
  logic [255:0] fill_data;
  logic [CNT_W-1:0] c_rh, c_wh, c_cp, c_cf, c_cr, c_cw;

  int n_vec = 0;
  int n_err = 0;

  // write log standing in for the shared level's contents
  logic [31:0] log_addr [16];
  logic [31:0] log_data [16];
  int          log_n = 0;

  localparam logic [31:0] A = 32'h100;  // slot 0
  localparam logic [31:0] B = 32'h140;  // slot 0, other tag
  localparam logic [31:0] C = 32'h120;  // slot 1
  localparam logic [31:0] D = 32'h160;  // slot 1, other tag

  snoop_l1_cache #(.CNT_W(CNT_W)) u_snoop_l1_cache (
    .clk(clk), .rst_n(rst_n),
    .core_req_valid(core_req_valid), .core_req_write(core_req_write),
    .core_req_addr(core_req_addr), .core_req_wdata(core_req_wdata),
    .core_req_ready(core_req_ready), .core_rsp_valid(core_rsp_valid),
    .core_rsp_rdata(core_rsp_rdata),
    .wt_valid(wt_valid), .wt_addr(wt_addr), .wt_data(wt_data),
    .snp_out_valid(snp_out_valid), .snp_out_addr(snp_out_addr),
    .snp_in_valid(snp_in_valid), .snp_in_addr(snp_in_addr),
    .fill_valid(fill_valid), .fill_addr(fill_addr),
    .fill_ready(fill_ready), .fill_data(fill_data),
    .cnt_clear(cnt_clear),
    .cnt_read_hit(c_rh), .cnt_write_hit(c_wh), .cnt_compulsory(c_cp),
    .cnt_conflict(c_cf), .cnt_coh_read(c_cr), .cnt_coh_write(c_cw)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [31:0] mem_word(input logic [31:0] addr);
    logic [31:0] wa = {addr[31:2], 2'b00};
    logic [31:0] v  = wa ^ 32'hA5A5_0000;
    for (int i = 0; i < log_n; i++) if (log_addr[i] == wa) v = log_data[i];
    return v;
  endfunction

  function automatic logic [255:0] mem_block(input logic [26:0] blk);
    logic [255:0] b;
    for (int w = 0; w < 8; w++) b[w*32 +: 32] = mem_word({blk, 5'b0} + 32'(w*4));
    return b;
  endfunction

  task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic check_counts(input string req, input int rh, input int wh, input int cp,
                              input int cf, input int cr, input int cw);
    check(req, "cnt_read_hit",   32'(c_rh), 32'(rh));
    check(req, "cnt_write_hit",  32'(c_wh), 32'(wh));
    check(req, "cnt_compulsory", 32'(c_cp), 32'(cp));
    check(req, "cnt_conflict",   32'(c_cf), 32'(cf));
    check(req, "cnt_coh_read",   32'(c_cr), 32'(cr));
    check(req, "cnt_coh_write",  32'(c_cw), 32'(cw));
  endtask

  task automatic clear_counts();
    @(negedge clk) cnt_clear = 1'b1;
    @(negedge clk) cnt_clear = 1'b0;
  endtask

  task automatic snoop(input logic [31:0] addr);
    @(negedge clk);
    snp_in_valid = 1'b1;
    snp_in_addr  = addr[31:5];
    @(negedge clk);
    snp_in_valid = 1'b0;
  endtask

  // read; miss expected -> fill with one extra stall cycle; optional same-cycle snoop
  task automatic do_read(input string req, input logic [31:0] addr, input bit miss, input bit with_snoop);
    @(negedge clk);
    core_req_valid = 1'b1; core_req_write = 1'b0; core_req_addr = addr;
    if (with_snoop) begin snp_in_valid = 1'b1; snp_in_addr = addr[31:5]; end
    @(negedge clk);
    core_req_valid = 1'b0; snp_in_valid = 1'b0;
    if (!miss) begin
      check(req, "hit rsp_valid", 32'(core_rsp_valid), 32'd1);
      check(req, "hit rdata", core_rsp_rdata, mem_word(addr));
      check(req, "hit no fill", 32'(fill_valid), 32'd0);
    end else begin
      check(req, "miss no rsp", 32'(core_rsp_valid), 32'd0);
      check(req, "fill_valid", 32'(fill_valid), 32'd1);
      check(req, "fill_addr", 32'(fill_addr), 32'(addr[31:5]));
      @(negedge clk);
      check(req, "stall ready low", 32'(core_req_ready), 32'd0);
      check(req, "fill held", 32'(fill_valid), 32'd1);
      fill_ready = 1'b1; fill_data = mem_block(addr[31:5]);
      @(negedge clk);
      fill_ready = 1'b0;
      check(req, "fill rsp_valid", 32'(core_rsp_valid), 32'd1);
      check(req, "fill rdata", core_rsp_rdata, mem_word(addr));
      check(req, "ready after fill", 32'(core_req_ready), 32'd1);
    end
  endtask

  task automatic do_write(input string req, input logic [31:0] addr, input logic [31:0] data);
    @(negedge clk);
    core_req_valid = 1'b1; core_req_write = 1'b1; core_req_addr = addr; core_req_wdata = data;
    @(negedge clk);
    core_req_valid = 1'b0; core_req_write = 1'b0;
    log_addr[log_n] = {addr[31:2], 2'b00}; log_data[log_n] = data; log_n++;
    check(req, "wt_valid", 32'(wt_valid), 32'd1);
    check(req, "wt_addr", wt_addr, addr);
    check(req, "wt_data", wt_data, data);
    check(req, "snp_out_valid", 32'(snp_out_valid), 32'd1);
    check(req, "snp_out_addr", 32'(snp_out_addr), 32'(addr[31:5]));
  endtask

  // ---------------- scenarios ----------------
  task automatic t_reset();
    check("R10", "reset cnt", 32'(c_rh | c_wh | c_cp | c_cf | c_cr | c_cw), 32'd0);
    check("R2", "reset ready", 32'(core_req_ready), 32'd1);
    check("R2", "reset fill_valid", 32'(fill_valid), 32'd0);
    check("R3", "reset wt_valid", 32'(wt_valid), 32'd0);
  endtask

  task automatic t_compulsory_then_hit();   // R6 R2 R1
    clear_counts();
    do_read("R6", A + 4, 1'b1, 1'b0);
    do_read("R1", A + 8, 1'b0, 1'b0);
    check_counts("R6", 1, 0, 1, 0, 0, 0);
  endtask

  task automatic t_write_hit();             // R3
    clear_counts();
    do_write("R3", A + 8, 32'hD1D1_0001);
    do_read("R3", A + 8, 1'b0, 1'b0);
    check_counts("R3", 1, 1, 0, 0, 0, 0);
  endtask

  task automatic t_no_allocate();           // R4
    clear_counts();
    do_write("R4", C, 32'hD2D2_0002);
    do_read("R4", C, 1'b1, 1'b0);
    do_read("R4", C, 1'b0, 1'b0);
    check_counts("R4", 1, 0, 2, 0, 0, 0);
  endtask

  task automatic t_snoop_invalidate();      // R5
    clear_counts();
    snoop(A);
    do_read("R5", A + 8, 1'b1, 1'b0);
    snoop(A);
    do_write("R5", A, 32'hD3D3_0003);
    do_read("R5", A, 1'b1, 1'b0);
    check_counts("R5", 0, 0, 0, 0, 2, 1);
  endtask

  task automatic t_snoop_ignored();         // R9
    clear_counts();
    snoop(B);
    snoop(D);
    do_read("R9", A, 1'b0, 1'b0);
    do_read("R9", C, 1'b0, 1'b0);
    check_counts("R9", 2, 0, 0, 0, 0, 0);
  endtask

  task automatic t_conflict();              // R7
    clear_counts();
    do_read("R7", B, 1'b1, 1'b0);
    do_read("R7", A, 1'b1, 1'b0);
    check_counts("R7", 0, 0, 0, 2, 0, 0);
  endtask

  task automatic t_same_cycle();            // R8
    clear_counts();
    do_read("R8", A + 4, 1'b1, 1'b1);
    check_counts("R8", 0, 0, 0, 0, 1, 0);
  endtask

  task automatic t_saturate();              // R10
    clear_counts();
    for (int i = 0; i < 17; i++) do_read("R10", A + 4, 1'b0, 1'b0);
    check("R10", "saturated read hits", 32'(c_rh), 32'd15);
    clear_counts();
    check_counts("R10", 0, 0, 0, 0, 0, 0);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog: run did not end, actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_err);
    $finish;
  end

  initial begin : stimulus
    rst_n = 1'b0;
    core_req_valid = 1'b0; core_req_write = 1'b0; core_req_addr = '0; core_req_wdata = '0;
    snp_in_valid = 1'b0; snp_in_addr = '0;
    fill_ready = 1'b0; fill_data = '0; cnt_clear = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_compulsory_then_hit();
    t_write_hit();
    t_no_allocate();
    t_snoop_invalidate();
    t_snoop_ignored();
    t_conflict();
    t_same_cycle();
    t_saturate();
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_err);
    $finish;
  end

endmodule